// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block is the command path of a hot-plug controller for an expansion bus with several slots. Software writes a 16-bit command word: the low byte is the opcode and the high byte is the target slot. The engine checks the command, runs it and reports the outcome in a small status field. Accepted commands hold a busy flag for a programmable number of cycles, which stands in for the real power sequencing of the slot hardware. When busy clears, the result takes effect and a one-cycle completion pulse goes to the interrupt logic. Rejected commands finish at once with an error code and change no state.

Each slot keeps three 2-bit fields: its state, a power indicator and an attention indicator. A slot opcode carries all three fields at once, and a zero field leaves the stored value alone. The engine also holds the current bus speed/mode setting, and it can move every slot to power-only or to enabled with one command. Speed/mode commands are checked against the programming interface level given by `iface_v2`.

Top module: `hpce_engine`

## Requirements
- R1: After reset, every slot reads state 3 (disabled) with both indicators 3 (off), the speed/mode value is 0, the status is 0 and `cmd_done` is low.
- R2: A command is `cmd_word[15:8]` = target slot and `cmd_word[7:0]` = opcode. Opcodes 00h–3Fh are slot operations. Opcode bits 1:0 give the new state (1 power-only, 2 enable, 3 disable), bits 3:2 give the power indicator and bits 5:4 give the attention indicator (1 on, 2 blink, 3 off). A zero field leaves its stored value unchanged.
- R3: Slot i reads back on `slot_view[6*i+5:6*i]`, with the state in bits 1:0, the power indicator in bits 3:2 and the attention indicator in bits 5:4, using the codes of R2.
- R4: An accepted valid command sets `status[0]` (busy) for exactly BUSY_CYCLES cycles. In the cycle after busy falls, its effect is visible and `cmd_done` is high for one cycle.
- R5: A command write while busy is set is ignored. This includes a write in the last busy cycle.
- R6: Opcodes 40h–44h set the speed/mode value to 0–4 (the low nibble of the opcode).
- R7: With `iface_v2` high, opcodes 50h–5Dh set the speed/mode value to 0–13 (the low nibble of the opcode).
- R8: With `iface_v2` low, an opcode in 50h–5Dh completes at once (`cmd_done` in the next cycle, no busy) with `status[3]` (invalid speed/mode) set, and the speed/mode value does not change.
- R9: Opcodes 45h–47h, 4Ah–4Fh and 5Eh–FFh, and any slot operation whose target is NUM_SLOTS or higher, complete at once with `status[2]` (invalid command) set and change nothing.
- R10: A slot operation whose state field is 1 or 2, sent to a slot whose `latch_open` bit is high, completes at once with `status[1]` (switch open) set and leaves the whole slot unchanged. A disable request is still allowed.
- R11: Opcode 48h sets every slot to state 1 and opcode 49h sets every slot to state 2. Both leave the indicators untouched. If any latch is open, the command completes at once with `status[1]` set and no slot changes.
- R12: With `iface_v2` low, `speed_mode` shows only the low 3 bits of the stored value, and `speed_ok` is high only when those bits are 4 or less. With `iface_v2` high, all 4 bits are shown and `speed_ok` is high when the value is 13 or less.
- R13: At most one error bit is set at a time. The error field holds until the next accepted command, which replaces it (with 0 for a valid command).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Target slot [15:8], opcode [7:0] |
| iface_v2 | input | 1 | Programming interface level 2 when high, level 1 when low |
| latch_open | input | NUM_SLOTS | Per-slot retention latch sensor, 1 = open |
| status | output | 4 | [0] busy, [1] switch open, [2] invalid command, [3] invalid speed/mode |
| cmd_done | output | 1 | One-cycle completion event to the interrupt logic |
| slot_view | output | 6*NUM_SLOTS | Per-slot state and indicator fields |
| speed_mode | output | 4 | Current speed/mode value |
| speed_ok | output | 1 | Speed/mode value is legal for the current interface level |

## Verification
The completion of a running command and the arrival of a new command write can fall in the same cycle. The bench holds `cmd_wr` high through every busy cycle, including the final one in which busy is about to clear. It judges the result by three things: completion is reported once, busy does not rise again, and the slot named in the rejected write keeps its old fields. A second overlap is an error command after an earlier error. It is checked by confirming that the new code replaces the old one instead of merging with it.

// File: rtl/hpce_pkg.sv
package hpce_pkg;
    localparam int unsigned VIEW_W = 6;

    localparam logic [2:0] ERR_NONE     = 3'b000;
    localparam logic [2:0] ERR_SWITCH   = 3'b001;
    localparam logic [2:0] ERR_BADCMD   = 3'b010;
    localparam logic [2:0] ERR_BADSPEED = 3'b100;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SLOT,
        ACT_SPEED,
        ACT_ALL
    } act_e;

    typedef struct packed {
        act_e        act;
        logic [7:0]  slot;
        logic [5:0]  fields;
        logic [3:0]  speed;
        logic [2:0]  err;
    } dec_t;
endpackage

// File: rtl/hpce_decode.sv
module hpce_decode
    import hpce_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [15:0]          cmd_word,
    input  logic                 iface_v2,
    input  logic [NUM_SLOTS-1:0] latch_open,
    output dec_t                 dec
);
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [7:0] op;
    logic [7:0] tgt;

    always_comb begin
        op  = cmd_word[7:0];
        tgt = cmd_word[15:8];
        dec = '0;
        dec.act  = ACT_NONE;
        dec.slot = tgt;
        if (op <= 8'h3F) begin
            if (tgt >= 8'(NUM_SLOTS)) begin
                dec.err = ERR_BADCMD;
            end else if ((op[1:0] == 2'd1 || op[1:0] == 2'd2)
                         && latch_open[tgt[IDX_W-1:0]]) begin
                dec.err = ERR_SWITCH;
            end else begin
                dec.act    = ACT_SLOT;
                dec.fields = op[5:0];
            end
        end else if (op >= 8'h40 && op <= 8'h44) begin
            dec.act   = ACT_SPEED;
            dec.speed = op[3:0];
        end else if (op == 8'h48 || op == 8'h49) begin
            if (|latch_open) begin
                dec.err = ERR_SWITCH;
            end else begin
                dec.act    = ACT_ALL;
                dec.fields = {4'b0000, op[0] ? 2'b10 : 2'b01};
            end
        end else if (op >= 8'h50 && op <= 8'h5D) begin
            if (!iface_v2) begin
                dec.err = ERR_BADSPEED;
            end else begin
                dec.act   = ACT_SPEED;
                dec.speed = op[3:0];
            end
        end else begin
            dec.err = ERR_BADCMD;
        end
    end
endmodule

// File: rtl/hpce_busy_timer.sv
module hpce_busy_timer #(
    parameter int unsigned BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic finish
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(BUSY_CYCLES - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy   = tmr_q.busy;
    assign finish = tmr_q.busy && (tmr_q.cnt == '0);
endmodule

// File: rtl/hpce_slot_reg.sv
module hpce_slot_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apply,
    input  logic [5:0] fields,
    output logic [5:0] view
);
    typedef struct packed {
        logic [1:0] attn;
        logic [1:0] pwr;
        logic [1:0] state;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (apply) begin
            if (fields[1:0] != 2'b00) slot_d.state = fields[1:0];
            if (fields[3:2] != 2'b00) slot_d.pwr   = fields[3:2];
            if (fields[5:4] != 2'b00) slot_d.attn  = fields[5:4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '{attn: 2'b11, pwr: 2'b11, state: 2'b11};
        else        slot_q <= slot_d;
    end

    assign view = slot_q;
endmodule

// File: rtl/hpce_engine.sv
module hpce_engine
    import hpce_pkg::*;
#(
    parameter int unsigned NUM_SLOTS   = 4,
    parameter int unsigned BUSY_CYCLES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_wr,
    input  logic [15:0]                 cmd_word,
    input  logic                        iface_v2,
    input  logic [NUM_SLOTS-1:0]        latch_open,
    output logic [3:0]                  status,
    output logic                        cmd_done,
    output logic [NUM_SLOTS*VIEW_W-1:0] slot_view,
    output logic [3:0]                  speed_mode,
    output logic                        speed_ok
);
    typedef struct packed {
        logic [2:0] err;
        logic       done;
        logic [3:0] speed;
        dec_t       pend;
    } eng_t;

    eng_t eng_d, eng_q;
    dec_t dec;
    logic busy, finish, accept, start;

    hpce_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
        .cmd_word   (cmd_word),
        .iface_v2   (iface_v2),
        .latch_open (latch_open),
        .dec        (dec)
    );

    hpce_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .finish (finish)
    );

    assign accept = cmd_wr && !busy;
    assign start  = accept && (dec.err == ERR_NONE);

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (finish) begin
            eng_d.done = 1'b1;
            if (eng_q.pend.act == ACT_SPEED) eng_d.speed = eng_q.pend.speed;
        end
        if (accept) begin
            eng_d.err  = dec.err;
            eng_d.pend = dec;
            if (dec.err != ERR_NONE) eng_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic hit;
        assign hit = finish && ((eng_q.pend.act == ACT_ALL) ||
                     (eng_q.pend.act == ACT_SLOT && eng_q.pend.slot == 8'(i)));
        hpce_slot_reg u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .apply  (hit),
            .fields (eng_q.pend.fields),
            .view   (slot_view[i*VIEW_W +: VIEW_W])
        );
    end

    assign status     = {eng_q.err, busy};
    assign cmd_done   = eng_q.done;
    assign speed_mode = iface_v2 ? eng_q.speed : {1'b0, eng_q.speed[2:0]};
    assign speed_ok   = iface_v2 ? (eng_q.speed <= 4'd13) : (eng_q.speed[2:0] <= 3'd4);
endmodule

// File: rtl/hpce_engine_chk.sv
module hpce_engine_chk #(
    parameter int unsigned NUM_SLOTS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_wr,
    input logic                   iface_v2,
    input logic [3:0]             status,
    input logic                   cmd_done,
    input logic [NUM_SLOTS*6-1:0] slot_view,
    input logic [3:0]             speed_mode
);
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !status[0]);

    // R4
    fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> cmd_done);

    // R5
    rise_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(cmd_wr));

    // R5
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && cmd_wr) |=> $stable(status[3:1]));

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |-> $stable(slot_view));

    // R13
    err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[3:1]));

    // R12
    narrow_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iface_v2 |-> !speed_mode[3]);
endmodule

bind hpce_engine hpce_engine_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .iface_v2   (iface_v2),
    .status     (status),
    .cmd_done   (cmd_done),
    .slot_view  (slot_view),
    .speed_mode (speed_mode)
);

// File: tb/hpce_engine_tb.sv
module hpce_engine_tb;
    localparam int NS = 4;
    localparam int BC = 5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_wr;
    logic [15:0]       cmd_word;
    logic              iface_v2;
    logic [NS-1:0]     latch_open;
    logic [3:0]        status;
    logic              cmd_done;
    logic [NS*6-1:0]   slot_view;
    logic [3:0]        speed_mode;
    logic              speed_ok;

    always #4 clk = ~clk;

    hpce_engine #(.NUM_SLOTS(NS), .BUSY_CYCLES(BC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .iface_v2(iface_v2), .latch_open(latch_open), .status(status),
        .cmd_done(cmd_done), .slot_view(slot_view), .speed_mode(speed_mode),
        .speed_ok(speed_ok)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [5:0] exp_v [NS];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic check_slots(input string req);
        for (int i = 0; i < NS; i++) chk(req, 32'(slot_view[i*6 +: 6]), 32'(exp_v[i]));
    endtask

    task automatic issue(input logic [7:0] slot, input logic [7:0] op);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = {slot, op};
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (status[0] && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_all_state(input logic [1:0] s);
        for (int i = 0; i < NS; i++) exp_v[i][1:0] = s;
    endtask

    task automatic t_reset;
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 done", 32'(cmd_done), 32'h0);
        chk("R1 speed", 32'(speed_mode), 32'h0);
        check_slots("R1 slots");
    endtask

    task automatic t_slot_fields;
        int n;
        issue(8'd1, 8'h2A);
        chk("R4 busy set", 32'(status), 32'h1);
        wait_idle(n);
        chk("R4 busy length", 32'(n), 32'(BC));
        chk("R4 done pulse", 32'(cmd_done), 32'h1);
        exp_v[1] = 6'h2A;
        check_slots("R2 fields applied");
        chk("R3 state field", 32'(slot_view[7:6]), 32'h2);
        @(negedge clk);
        chk("R4 done one cycle", 32'(cmd_done), 32'h0);
        issue(8'd1, 8'h10);
        wait_idle(n);
        exp_v[1] = 6'h1A;
        check_slots("R2 zero fields kept");
    endtask

    task automatic t_ignore;
        issue(8'd2, 8'h01);
        cmd_word = {8'd3, 8'h01};
        cmd_wr   = 1'b1;
        while (status[0]) @(negedge clk);
        cmd_wr   = 1'b0;
        chk("R5 first completes", 32'(cmd_done), 32'h1);
        @(negedge clk);
        chk("R5 no restart", 32'(status[0]), 32'h0);
        exp_v[2] = 6'h3D;
        check_slots("R5 write during busy ignored");
    endtask

    task automatic t_speed;
        int n;
        iface_v2 = 1'b0;
        issue(8'd0, 8'h43);
        wait_idle(n);
        chk("R6 mode A speed", 32'(speed_mode), 32'h3);
        chk("R12 ok iface1", 32'(speed_ok), 32'h1);
        issue(8'd0, 8'h55);
        chk("R8 status", 32'(status), 32'h8);
        chk("R8 done at once", 32'(cmd_done), 32'h1);
        chk("R8 speed kept", 32'(speed_mode), 32'h3);
        iface_v2 = 1'b1;
        issue(8'd0, 8'h5D);
        chk("R13 error replaced", 32'(status), 32'h1);
        wait_idle(n);
        chk("R7 mode B speed", 32'(speed_mode), 32'hD);
        chk("R12 ok iface2", 32'(speed_ok), 32'h1);
        issue(8'd0, 8'h5E);
        chk("R9 5Eh invalid", 32'(status), 32'h4);
        iface_v2 = 1'b0;
        @(negedge clk);
        chk("R12 narrow view", 32'(speed_mode), 32'h5);
        chk("R12 not ok", 32'(speed_ok), 32'h0);
        issue(8'd0, 8'h40);
        wait_idle(n);
        chk("R6 back to 0", 32'(speed_mode), 32'h0);
    endtask

    task automatic t_reserved;
        issue(8'd0, 8'h46);
        chk("R9 46h", 32'(status), 32'h4);
        chk("R9 done", 32'(cmd_done), 32'h1);
        issue(8'd0, 8'h60);
        chk("R9 60h", 32'(status), 32'h4);
        issue(8'd0, 8'hC5);
        chk("R9 C5h", 32'(status), 32'h4);
        issue(8'd4, 8'h01);
        chk("R9 slot range", 32'(status), 32'h4);
        @(negedge clk);
        check_slots("R9 nothing changed");
        chk("R9 speed kept", 32'(speed_mode), 32'h0);
    endtask

    task automatic t_latch;
        int n;
        latch_open = 4'b0001;
        issue(8'd0, 8'h02);
        chk("R10 switch open", 32'(status), 32'h2);
        chk("R10 done", 32'(cmd_done), 32'h1);
        @(negedge clk);
        check_slots("R10 slot unchanged");
        issue(8'd0, 8'h13);
        chk("R13 error cleared", 32'(status), 32'h1);
        wait_idle(n);
        chk("R13 ends clean", 32'(status), 32'h0);
        exp_v[0] = 6'h1F;
        check_slots("R10 disable allowed");
    endtask

    task automatic t_all;
        int n;
        issue(8'd0, 8'h49);
        chk("R11 switch open", 32'(status), 32'h2);
        @(negedge clk);
        check_slots("R11 nothing changed");
        latch_open = '0;
        issue(8'd0, 8'h49);
        wait_idle(n);
        set_all_state(2'd2);
        check_slots("R11 enable all");
        issue(8'd0, 8'h48);
        wait_idle(n);
        set_all_state(2'd1);
        check_slots("R11 power-only all");
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_wr = 1'b0;
        cmd_word = '0;
        iface_v2 = 1'b0;
        latch_open = '0;
        for (int i = 0; i < NS; i++) exp_v[i] = 6'h3F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slot_fields();
        t_ignore();
        t_speed();
        t_reserved();
        t_latch();
        t_all();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule